// File: doc/BRIEF.md
# Packed Dot-Product Accumulate Unit

This block is a SIMD datapath stage that splits a vector into 32-bit lanes. In each lane it forms a short dot product from sub-elements of two source vectors and adds that dot product to a 32-bit accumulator taken from a third vector. In byte mode each lane multiplies four unsigned bytes of the first source by four signed bytes of the second source. In word mode each lane multiplies two signed halfword pairs. The accumulate either wraps modulo 2^32 or clamps to the signed 32-bit range.

An 8-bit lane mask sets which lanes take the new value. A lane whose mask bit is clear either keeps its accumulator input (merge) or outputs zero (zeroing). A parameter sets the vector width to 128 or 256 bits. The ports are always 256 bits wide, and any result bits above the configured width read as zero. The result is registered. It appears one clock after an input that is flagged valid, together with an output-valid strobe.

Top module: `dotacc_unit`

## Requirements
- R1: When `op_word`=0 (byte mode), lane j adds to `acc_in[32j+31:32j]` four products. For k=0..3, each product is byte 4j+k of `src_a` (taken as unsigned 0..255) times byte 4j+k of `src_b` (taken as signed -128..127).
- R2: When `op_word`=1 (word mode), lane j adds two products. For k=0..1, each product is halfword 2j+k of `src_a` times halfword 2j+k of `src_b`, both taken as signed 16-bit values.
- R3: When `sat_en`=0, the lane result is the low 32 bits of the accumulator plus the products, so it wraps modulo 2^32.
- R4: When `sat_en`=1, the exact sum sets the lane result. A sum above 2^31-1 gives 0x7FFFFFFF, and a sum below -2^31 gives 0x80000000. For example, word mode with two products of 0x8000 times 0x8000 on a zero accumulator gives 0x7FFFFFFF.
- R5: When `lane_mask[j]`=0 and `zero_mode`=0, lane j outputs its `acc_in` lane unchanged.
- R6: When `lane_mask[j]`=0 and `zero_mode`=1, lane j outputs zero.
- R7: `VEC_W`=256 gives 8 lanes and `VEC_W`=128 gives 4 lanes. With 4 lanes, `result[255:128]` is always zero.
- R8: With `VEC_W`=128, `lane_mask[7:4]` has no effect on `result`.
- R9: `result` and `out_valid` are registered. While `rst_n` is low both are zero. One cycle after a clock edge with `in_valid`=1, `out_valid` is 1 and `result` holds the new value. After an edge with `in_valid`=0, `out_valid` is 0 and `result` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands valid this cycle |
| op_word | input | 1 | 0 = byte mode, 1 = word mode |
| sat_en | input | 1 | 1 = saturate, 0 = wrap |
| zero_mode | input | 1 | Masked-off lane: 1 = zero, 0 = keep accumulator |
| lane_mask | input | 8 | Bit j enables lane j |
| acc_in | input | 256 | Accumulator lanes |
| src_a | input | 256 | First source (unsigned bytes or signed halfwords) |
| src_b | input | 256 | Second source (signed bytes or signed halfwords) |
| out_valid | output | 1 | Result valid |
| result | output | 256 | Lane results |

## Verification
Every result is due exactly one rising edge after the operands are presented with `in_valid` high. The bench drives operands on a falling edge and then waits one full clock. It compares `result` and `out_valid` on the following falling edge, half a period after the capturing edge. For the hold behaviour, it drops `in_valid`, changes every operand, and lets two rising edges pass before it checks that `result` has not moved. The bench uses a 256-bit instance and a 128-bit instance side by side, so the lane-count and mask-width rules are checked against the same stimulus.

// File: rtl/dotacc_unit.sv
module dotacc_unit #(
  parameter int VEC_W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         op_word,
  input  logic         sat_en,
  input  logic         zero_mode,
  input  logic [7:0]   lane_mask,
  input  logic [255:0] acc_in,
  input  logic [255:0] src_a,
  input  logic [255:0] src_b,
  output logic         out_valid,
  output logic [255:0] result
);
  localparam int PORT_W    = 256;
  localparam int LANE_W    = 32;
  localparam int MAX_LANES = PORT_W / LANE_W;
  localparam int LANES     = VEC_W / LANE_W;
  localparam int SW        = 36;

  logic [PORT_W-1:0] nxt;

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    if (i < LANES) begin : g_on
      logic signed [16:0] pb [4];
      logic signed [31:0] pw [2];
      logic signed [SW-1:0] acc_x, bsum, wsum, total;
      logic over, under;
      logic [31:0] lane_new;

      for (genvar k = 0; k < 4; k++) begin : g_b
        logic [7:0] a8, b8;
        assign a8 = src_a[i*32 + k*8 +: 8];
        assign b8 = src_b[i*32 + k*8 +: 8];
        assign pb[k] = $signed({9'b0, a8}) * $signed({{9{b8[7]}}, b8});
      end

      for (genvar k = 0; k < 2; k++) begin : g_w
        logic [15:0] a16, b16;
        assign a16 = src_a[i*32 + k*16 +: 16];
        assign b16 = src_b[i*32 + k*16 +: 16];
        assign pw[k] = $signed({{16{a16[15]}}, a16}) * $signed({{16{b16[15]}}, b16});
      end

      assign acc_x = {{(SW-32){acc_in[i*32+31]}}, acc_in[i*32 +: 32]};
      assign bsum  = acc_x
                   + {{(SW-17){pb[0][16]}}, pb[0]} + {{(SW-17){pb[1][16]}}, pb[1]}
                   + {{(SW-17){pb[2][16]}}, pb[2]} + {{(SW-17){pb[3][16]}}, pb[3]};
      assign wsum  = acc_x
                   + {{(SW-32){pw[0][31]}}, pw[0]} + {{(SW-32){pw[1][31]}}, pw[1]};
      assign total = op_word ? wsum : bsum;

      assign over  = ~total[SW-1] &  (|total[SW-2:31]);
      assign under =  total[SW-1] & ~(&total[SW-2:31]);

      assign lane_new = !sat_en ? total[31:0] :
                        over    ? 32'h7FFF_FFFF :
                        under   ? 32'h8000_0000 : total[31:0];

      assign nxt[i*32 +: 32] = lane_mask[i] ? lane_new :
                               zero_mode    ? 32'h0 : acc_in[i*32 +: 32];
    end else begin : g_off
      assign nxt[i*32 +: 32] = 32'h0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

module dotacc_unit_chk #(
  parameter int VEC_W = 256
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         zero_mode,
  input logic [7:0]   lane_mask,
  input logic [255:0] acc_in,
  input logic         out_valid,
  input logic [255:0] result
);
  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  // R5
  merge_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !zero_mode && !lane_mask[0]) |=> (result[31:0] == $past(acc_in[31:0])));

  // R6
  zero_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && zero_mode && !lane_mask[1]) |=> (result[63:32] == 32'h0));

  if (VEC_W == 128) begin : g_narrow
    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result[255:128] == 128'h0);
  end
endmodule

bind dotacc_unit dotacc_unit_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/dotacc_unit_bench.sv
module dotacc_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, op_word = 1'b0, sat_en = 1'b0, zero_mode = 1'b0;
  logic [7:0] lane_mask = 8'h0;
  logic [255:0] acc_in = '0, src_a = '0, src_b = '0;
  logic ov256, ov128;
  logic [255:0] res256, res128;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dotacc_unit #(.VEC_W(256)) u_dotacc_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_word(op_word),
    .sat_en(sat_en), .zero_mode(zero_mode), .lane_mask(lane_mask),
    .acc_in(acc_in), .src_a(src_a), .src_b(src_b),
    .out_valid(ov256), .result(res256));

  dotacc_unit #(.VEC_W(128)) u_dotacc_unit_128 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_word(op_word),
    .sat_en(sat_en), .zero_mode(zero_mode), .lane_mask(lane_mask),
    .acc_in(acc_in), .src_a(src_a), .src_b(src_b),
    .out_valid(ov128), .result(res128));

  function automatic logic [255:0] model(int lanes, logic wm, logic sat, logic zm,
      logic [7:0] m, logic [255:0] s, logic [255:0] a, logic [255:0] b);
    logic [255:0] r = '0;
    for (int j = 0; j < 8; j++) begin
      int acc;
      longint t;
      acc = s[j*32 +: 32];
      t = longint'(acc);
      if (wm) begin
        for (int k = 0; k < 2; k++) begin
          shortint x, y;
          x = a[j*32 + k*16 +: 16];
          y = b[j*32 + k*16 +: 16];
          t = t + longint'(x) * longint'(y);
        end
      end else begin
        for (int k = 0; k < 4; k++) begin
          int ua;
          byte y;
          ua = int'(a[j*32 + k*8 +: 8]);
          y = b[j*32 + k*8 +: 8];
          t = t + longint'(ua) * longint'(y);
        end
      end
      if (sat) begin
        if (t > 64'sd2147483647) t = 64'sd2147483647;
        if (t < -64'sd2147483648) t = -64'sd2147483648;
      end
      if (j >= lanes) r[j*32 +: 32] = '0;
      else if (m[j]) r[j*32 +: 32] = 32'(t);
      else if (zm) r[j*32 +: 32] = '0;
      else r[j*32 +: 32] = s[j*32 +: 32];
    end
    return r;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(string tag, logic [255:0] got, logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic fire(string tag, logic wm, logic sat, logic zm, logic [7:0] m,
                      logic [255:0] s, logic [255:0] a, logic [255:0] b);
    @(negedge clk);
    in_valid = 1'b1; op_word = wm; sat_en = sat; zero_mode = zm;
    lane_mask = m; acc_in = s; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " w256"}, res256, model(8, wm, sat, zm, m, s, a, b));
    chk({tag, " w128"}, res128, model(4, wm, sat, zm, m, s, a, b));
    chk({tag, " R9 valid"}, {254'b0, ov256, ov128}, {254'b0, 2'b11});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 reset result", res256 | res128, '0);
    chk("R9 reset valid", {254'b0, ov256, ov128}, '0);
  endtask

  task automatic t_byte();
    for (int i = 0; i < 20; i++)
      fire("R1 R3 byte random", 1'b0, 1'b0, 1'b0, 8'hFF, rnd256(), rnd256(), rnd256());
    fire("R1 byte FFx80", 1'b0, 1'b0, 1'b0, 8'hFF, '0, {32{8'hFF}}, {32{8'h80}});
    fire("R1 byte FFx7F", 1'b0, 1'b1, 1'b0, 8'hFF, {8{32'h7FFF_FF00}}, {32{8'hFF}}, {32{8'h7F}});
  endtask

  task automatic t_word();
    for (int i = 0; i < 20; i++)
      fire("R2 word random", 1'b1, $urandom_range(1), 1'b0, 8'hFF, rnd256(), rnd256(), rnd256());
  endtask

  task automatic t_wrap_sat();
    fire("R3 word wrap", 1'b1, 1'b0, 1'b0, 8'hFF, '0, {16{16'h8000}}, {16{16'h8000}});
    chk("R3 wrap lane0", {224'b0, res256[31:0]}, {224'b0, 32'h8000_0000});
    fire("R4 word sat high", 1'b1, 1'b1, 1'b0, 8'hFF, '0, {16{16'h8000}}, {16{16'h8000}});
    chk("R4 sat lane0", {224'b0, res256[31:0]}, {224'b0, 32'h7FFF_FFFF});
    fire("R4 byte sat low", 1'b0, 1'b1, 1'b0, 8'hFF, {8{32'h8000_0010}}, {32{8'hFF}}, {32{8'h80}});
    chk("R4 sat low lane0", {224'b0, res256[31:0]}, {224'b0, 32'h8000_0000});
    fire("R3 byte wrap low", 1'b0, 1'b0, 1'b0, 8'hFF, {8{32'h8000_0010}}, {32{8'hFF}}, {32{8'h80}});
    for (int i = 0; i < 10; i++)
      fire("R4 near limits", $urandom_range(1), 1'b1, 1'b0, 8'hFF,
           {4{32'h7FFF_FFF0, 32'h8000_0005}}, rnd256(), rnd256());
  endtask

  task automatic t_mask();
    logic [255:0] s;
    s = rnd256();
    fire("R5 merge", 1'b0, 1'b0, 1'b0, 8'hA5, s, rnd256(), rnd256());
    chk("R5 merge lane1", {224'b0, res256[63:32]}, {224'b0, s[63:32]});
    fire("R6 zero", 1'b1, 1'b1, 1'b1, 8'h5A, s, rnd256(), rnd256());
    chk("R6 zero lane0", {224'b0, res256[31:0]}, '0);
    fire("R5 all off merge", 1'b1, 1'b0, 1'b0, 8'h00, s, rnd256(), rnd256());
    fire("R6 all off zero", 1'b0, 1'b0, 1'b1, 8'h00, s, rnd256(), rnd256());
  endtask

  task automatic t_narrow();
    logic [255:0] s, a, b, first;
    s = rnd256(); a = rnd256(); b = rnd256();
    fire("R8 mask low only", 1'b0, 1'b0, 1'b1, 8'h0F, s, a, b);
    first = res128;
    fire("R8 mask full", 1'b0, 1'b0, 1'b1, 8'hFF, s, a, b);
    chk("R8 upper mask ignored", res128, first);
    fire("R7 narrow merge", 1'b1, 1'b0, 1'b0, 8'hF0, s, a, b);
    chk("R7 upper zero", {128'b0, res128[255:128]}, '0);
  endtask

  task automatic t_hold();
    logic [255:0] keep;
    fire("R9 pre hold", 1'b0, 1'b0, 1'b0, 8'hFF, rnd256(), rnd256(), rnd256());
    keep = res256;
    @(negedge clk);
    acc_in = rnd256(); src_a = rnd256(); src_b = rnd256(); lane_mask = 8'h3C;
    @(negedge clk);
    @(negedge clk);
    chk("R9 hold result", res256, keep);
    chk("R9 idle valid", {254'b0, ov256, ov128}, '0);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_byte();
    t_word();
    t_wrap_sat();
    t_mask();
    t_narrow();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule